// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Lane Writes

This block is a single-port synchronous memory for on-chip storage. Each word is 36 bits, split into four 9-bit lanes, and the depth is set by an address-width parameter. On every rising clock edge the block captures the address, write data, three chip-select inputs and the write controls. A captured read presents its word on the output one edge later, through a registered output stage. A captured write updates the array on the following edge.

A write has two sources. A global strobe writes every lane. Otherwise, a lane-write enable together with per-lane strobes writes any chosen subset of lanes. If the controls select no lane, the cycle is a read. The data bus is split into an input, an output and a drive-enable flag. The drive flag has one fewer register stage in its path than a deselect would need if it were timed like read data. As a result, a deselect releases the bus on the same edge at which a read's data would have appeared, and a captured write releases it at once. An output-enable input and a sleep input gate the drive flag without waiting for the clock. While sleep is high, new commands are dropped and the stored contents are kept.

Top module: `pipe_sram`

## Requirements
- R1: When `wr_all_n` is low on a selected edge, all four lanes of the addressed word take `din`, whatever the values of `wr_lane_en_n` and `lane_n`.
- R2: When `wr_all_n` is high and `wr_lane_en_n` is low, only lanes k with `lane_n[k]` low are written. Lane k occupies bits 9k+8 down to 9k. Every other lane keeps its old value.
- R3: When `wr_all_n` is high, the cycle is a read if `wr_lane_en_n` is high or if all of `lane_n` are high. In that case the array is not changed.
- R4: A read captured at edge n drives `dout_en` high after edge n+1, with all 36 bits of the addressed word on `dout`, whatever the lane strobes were.
- R5: A write captured at edge n holds `dout_en` low from just after edge n until edge n+2. This also cuts off data from a read captured at edge n-1.
- R6: The block is selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Any other combination is a deselect. A deselect captured at edge n leaves the array unchanged and drives `dout_en` low after edge n+1.
- R7: While `oe_n` is high, `dout_en` is low without waiting for a clock edge. The pipeline keeps running, so driving `oe_n` low again restores the pending output.
- R8: While `sleep` is high, `dout_en` is low without waiting for a clock edge, captured reads and writes are ignored, and the stored data is kept for use after `sleep` falls.
- R9: While `rst_n` is low, `dout_en` is low and no command is pending.
- R10: Reads to different addresses on consecutive edges deliver one word per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data, lane k in bits 9k+8:9k |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Drive flag for `dout` |

## Verification
A vector table interleaves global writes, with the lane strobes both asserted and idle, lane writes to a single lane and to a pair of lanes, a lane-write enable with no lane strobe, and back-to-back reads. Reading the words back separates a global write from a lane write, and separates an empty lane selection from a write. A read directly followed by a write or by each kind of deselect shows when the drive flag turns on and off, and whether a write hides the previous read's data. Directed cases raise `oe_n` and `sleep` between clock edges and attempt a write during sleep. Reading the word afterwards shows that the command was dropped and the data was kept.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             sleep,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_n,
  output op_e              op,
  output logic [LANES-1:0] mask
);
  logic selected;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n && !sleep;
    if (!wr_all_n) begin
      mask = '1;
    end else if (!wr_lane_en_n) begin
      mask = ~lane_n;
    end else begin
      mask = '0;
    end
    if (!selected) begin
      op = OP_NONE;
    end else if (|mask) begin
      op = OP_WRITE;
    end else begin
      op = OP_READ;
    end
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         mask,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;
    logic              lane_we;

    always_comb lane_we = wr_en && mask[g];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) begin
        lane_q <= lane_mem[addr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/psram_drive.sv
module psram_drive
  import psram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  cap_op,
  input  logic oe_n,
  input  logic sleep,
  output logic dout_en
);
  logic drv_q, drv_nxt;

  always_comb drv_nxt = (cap_op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
    end else begin
      drv_q <= drv_nxt;
    end
  end

  always_comb dout_en = drv_q && (cap_op != OP_WRITE) && !oe_n && !sleep;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               dec_op;
  logic [LANES-1:0]  dec_mask;
  op_e               cap_op, cap_op_nxt;
  logic              cap_ld;
  logic [ADDR_W-1:0] cap_addr, cap_addr_nxt;
  logic [DATA_W-1:0] cap_din, cap_din_nxt;
  logic [LANES-1:0]  cap_mask, cap_mask_nxt;

  psram_decode #(.LANES(LANES)) u_decode (
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .sleep        (sleep),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_n       (lane_n),
    .op           (dec_op),
    .mask         (dec_mask)
  );

  always_comb begin
    cap_op_nxt   = dec_op;
    cap_ld       = (dec_op != OP_NONE);
    cap_addr_nxt = cap_ld ? addr : cap_addr;
    cap_din_nxt  = cap_ld ? din : cap_din;
    cap_mask_nxt = cap_ld ? dec_mask : cap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op <= OP_NONE;
    end else begin
      cap_op <= cap_op_nxt;
    end
  end

  always_ff @(posedge clk) begin
    cap_addr <= cap_addr_nxt;
    cap_din  <= cap_din_nxt;
    cap_mask <= cap_mask_nxt;
  end

  psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .wr_en (cap_op == OP_WRITE),
    .rd_en (cap_op == OP_READ),
    .addr  (cap_addr),
    .mask  (cap_mask),
    .wdata (cap_din),
    .rdata (dout)
  );

  psram_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_op  (cap_op),
    .oe_n    (oe_n),
    .sleep   (sleep),
    .dout_en (dout_en)
  );

  // Port-level command views used only by the checks below
  logic chk_sel, chk_wr, chk_rd, chk_desel;
  always_comb begin
    chk_desel = sel_a_n || !sel_b || sel_c_n;
    chk_sel   = !chk_desel && !sleep;
    chk_wr    = chk_sel && (!wr_all_n || (!wr_lane_en_n && (lane_n != '1)));
    chk_rd    = chk_sel && !chk_wr;
  end

  p_gw_all_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_sel && !wr_all_n) |=> (cap_mask == '1 && cap_op == OP_WRITE));

  p_rd_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rd |-> ##2 (dout_en || oe_n || sleep || $past(chk_wr)));

  p_wr_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |=> !dout_en);

  p_desel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_desel |-> ##2 !dout_en);

  p_sleep_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cap_op == OP_NONE));
endmodule

// File: tb/pipe_sram_bench.sv
module pipe_sram_bench;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int NV     = 17;
  localparam logic [2:0] ON = 3'b010; // {sel_a_n, sel_b, sel_c_n}

  // {chip[2:0], gw_n, bwe_n, lane_n[3:0], addr[7:0], din[35:0], exp_en}
  localparam logic [53:0] TBL [NV] = '{
    {ON,     1'b0, 1'b1, 4'hF, 8'h01, 36'h123456789, 1'b0}, // R1 gw, strobes idle
    {ON,     1'b0, 1'b0, 4'hF, 8'h02, 36'hABCDEF012, 1'b0}, // R1 gw, lane enable low
    {ON,     1'b1, 1'b1, 4'h0, 8'h01, 36'h000000000, 1'b0}, // R3 read, strobes low
    {ON,     1'b1, 1'b1, 4'h0, 8'h02, 36'h000000000, 1'b1}, // R4
    {ON,     1'b1, 1'b0, 4'hA, 8'h01, 36'hFFFFFFFFF, 1'b0}, // R2 lanes 0,2; R5
    {ON,     1'b1, 1'b1, 4'hF, 8'h01, 36'h000000000, 1'b0}, // R5
    {3'b000, 1'b1, 1'b1, 4'hF, 8'h03, 36'h000000000, 1'b1}, // R6 sel_b low
    {3'b110, 1'b1, 1'b1, 4'hF, 8'h03, 36'h000000000, 1'b0}, // R6 sel_a_n high
    {ON,     1'b1, 1'b0, 4'hF, 8'h02, 36'h555555555, 1'b0}, // R3 no lane strobe
    {ON,     1'b1, 1'b1, 4'hF, 8'h01, 36'h000000000, 1'b1}, // R10
    {ON,     1'b1, 1'b1, 4'hF, 8'h02, 36'h000000000, 1'b1}, // R10
    {ON,     1'b0, 1'b1, 4'hF, 8'h03, 36'h5A5A5A5A5, 1'b0}, // R5 cuts read
    {ON,     1'b1, 1'b1, 4'hF, 8'h03, 36'h000000000, 1'b0},
    {ON,     1'b1, 1'b0, 4'h7, 8'h03, 36'hFFFFFFFFF, 1'b0}, // R2 lane 3
    {ON,     1'b1, 1'b1, 4'hF, 8'h03, 36'h000000000, 1'b0},
    {3'b011, 1'b1, 1'b1, 4'hF, 8'h00, 36'h000000000, 1'b1}, // R6 sel_c_n high
    {3'b011, 1'b1, 1'b1, 4'hF, 8'h00, 36'h000000000, 1'b0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     din;
  logic              sel_a_n, sel_b, sel_c_n;
  logic              wr_all_n, wr_lane_en_n;
  logic [LANES-1:0]  lane_n;
  logic              oe_n, sleep;
  logic [DW-1:0]     dout;
  logic              dout_en;

  pipe_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_n(lane_n),
    .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [DW-1:0] shadow [1 << ADDR_W];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] chip, input logic gw, input logic bwe,
                     input logic [3:0] ln, input logic [7:0] a, input logic [DW-1:0] d);
    {sel_a_n, sel_b, sel_c_n} = chip;
    wr_all_n = gw; wr_lane_en_n = bwe; lane_n = ln; addr = a; din = d;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] lanes_of(input logic gw, input logic bwe, input logic [3:0] ln);
    if (!gw) return 4'hF;
    if (!bwe) return ~ln;
    return 4'h0;
  endfunction

  // read one word: capture, then deselect so the word shows after the next edge
  task automatic rd_word(input logic [7:0] a, output logic [DW-1:0] w, output logic e);
    put(ON, 1'b1, 1'b1, 4'hF, a, '0);
    step();
    put(3'b110, 1'b1, 1'b1, 4'hF, a, '0);
    step();
    w = dout; e = dout_en;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [53:0]   v;
    logic [DW-1:0] exp_data, w;
    logic          e;
    logic [3:0]    m;
    bit            is_sel, is_wr, is_rd, prev_rd;
    string         tag;

    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    put(3'b110, 1'b1, 1'b1, 4'hF, '0, '0);
    for (int k = 0; k < (1 << ADDR_W); k++) shadow[k] = '0;
    repeat (3) step();
    chk(dout_en == 1'b0, "R9 reset drive", {35'd0, dout_en}, '0);
    rst_n = 1'b1;
    step();
    chk(dout_en == 1'b0, "R9 after release", {35'd0, dout_en}, '0);

    exp_data = '0; prev_rd = 1'b0;
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      put(v[53:51], v[50], v[49], v[48:45], v[44:37], v[36:1]);
      is_sel = (v[53:51] == ON);
      m      = lanes_of(v[50], v[49], v[48:45]);
      is_wr  = is_sel && (m != 4'h0);
      is_rd  = is_sel && (m == 4'h0);
      step();
      if (is_wr)       tag = "R5 write hides bus";
      else if (!is_sel) tag = "R6 deselect timing";
      else if (prev_rd) tag = "R10 read stream";
      else             tag = "R4 read drive";
      chk(dout_en == v[0], tag, {35'd0, dout_en}, {35'd0, v[0]});
      if (v[0]) chk(dout == exp_data, "R4 full word", dout, exp_data);
      if (is_wr) begin
        for (int k = 0; k < LANES; k++)
          if (m[k]) shadow[v[44:37]][k*LANE_W +: LANE_W] = v[k*LANE_W + 1 +: LANE_W];
      end
      if (is_rd) exp_data = shadow[v[44:37]];
      prev_rd = is_rd;
    end

    // hand-worked contents
    rd_word(8'h01, w, e);
    chk(e && w == 36'h127FD67FF, "R2 lanes 0 and 2 only", w, 36'h127FD67FF);
    rd_word(8'h02, w, e);
    chk(e && w == 36'hABCDEF012, "R3 empty lane set kept word", w, 36'hABCDEF012);
    rd_word(8'h03, w, e);
    chk(e && w == 36'hFFDA5A5A5, "R1 then R2 lane 3", w, 36'hFFDA5A5A5);

    // R7: output enable acts between edges
    put(ON, 1'b1, 1'b1, 4'hF, 8'h02, '0);
    step(); step();
    chk(dout_en == 1'b1, "R7 baseline drive", {35'd0, dout_en}, 36'd1);
    oe_n = 1'b1; #1;
    chk(dout_en == 1'b0, "R7 oe_n high", {35'd0, dout_en}, '0);
    oe_n = 1'b0; #1;
    chk(dout_en == 1'b1 && dout == 36'hABCDEF012, "R7 restore", dout, 36'hABCDEF012);

    // R8: sleep gates at once, drops commands, keeps data
    sleep = 1'b1; #1;
    chk(dout_en == 1'b0, "R8 sleep gates drive", {35'd0, dout_en}, '0);
    put(ON, 1'b0, 1'b1, 4'hF, 8'h02, 36'h000000000);
    step();
    chk(dout_en == 1'b0, "R8 sleep write", {35'd0, dout_en}, '0);
    put(ON, 1'b1, 1'b1, 4'hF, 8'h02, '0);
    step();
    chk(dout_en == 1'b0, "R8 sleep read", {35'd0, dout_en}, '0);
    sleep = 1'b0;
    step();
    chk(dout_en == 1'b0, "R8 dropped read gives no data", {35'd0, dout_en}, '0);
    step();
    chk(dout_en == 1'b1 && dout == 36'hABCDEF012, "R8 data retained", dout, 36'hABCDEF012);

    // R9: reset drops the drive flag at once
    rst_n = 1'b0; #1;
    chk(dout_en == 1'b0, "R9 async reset", {35'd0, dout_en}, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule